// File: doc/BRIEF.md
# Linear Image Sensor Section Sequencer

This block holds the digital timing of one 64-pixel section of a linear photosensor array. A start token, seen high on a rising clock edge while the section is idle, opens an output period. For the next 64 clock periods the block walks a one-hot pixel select from the first pixel to the last. It reports the pixel number and holds an output enable high. Within each clock period it also produces a sample strobe and a sense-node reset strobe, and the two never overlap.

With the last pixel the block raises a chain output for one period. That pulse can feed the start input of the next section, so chained sections read out with no gap. The edge after the last pixel empties the select register and drops the enable, and the section stays idle until a new start. A start that arrives while a period is running does not disturb the sequence. Instead the block flags it for one cycle.

Top module: `lss_section_seq`

## Requirements
- R1: When `si` is high at a rising edge and `out_en` is low, the next cycle shows `pix_idx` = 1 and `pix_sel` = bit 0 only (bit k-1 of `pix_sel` selects pixel k).
- R2: While a period runs, each rising edge advances the pixel by one. After the k-th edge of the period (k = 1..64), `pix_idx` = k and `pix_sel` has only bit k-1 set.
- R3: `so` is high for exactly the one cycle in which pixel 64 is presented, and is low at all other times.
- R4: The 65th edge of a period clears `pix_sel` to zero, sets `pix_idx` to 0 and drives `out_en` low.
- R5: `out_en` is high for exactly 64 consecutive cycles per period and low while idle. When idle, `pix_idx` is 0 and `pix_sel` is zero.
- R6: `sample_hold` equals `clk` AND `out_en`: it samples in the high clock phase of a period cycle and holds in the low phase.
- R7: `node_reset` is high in every low clock phase and low in every high phase, so it is never high together with `sample_hold`.
- R8: When `si` is high at an edge that falls inside a period (edges 2..65 after a start), the sequence is unchanged and `si_violation` is high for the following cycle only. An `si` pulse on edge 66 after a start opens a new period.
- R9: A synchronous active-high `rst` at a rising edge returns the block to idle: `pix_idx` = 0, `pix_sel` = 0, `out_en`, `so` and `si_violation` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edges step the pixels |
| rst | input | 1 | Synchronous active-high reset |
| si | input | 1 | Start token; opens a period when idle |
| pix_idx | output | $clog2(NUM_PIX+1) | Current pixel number 1..NUM_PIX, 0 when idle |
| pix_sel | output | NUM_PIX | One-hot pixel select |
| out_en | output | 1 | High during the output period |
| sample_hold | output | 1 | Sample strobe, high in the high clock phase of a period cycle |
| node_reset | output | 1 | Sense-node reset strobe, high in every low clock phase |
| so | output | 1 | Chain output, high with the last pixel |
| si_violation | output | 1 | One-cycle flag for a start ignored during a period |

## Verification
The hardest situation to reach is the boundary between the end of one period and the start of the next. At that boundary a start on edge 65 must be rejected and flagged, while a start one edge later must open a new period. The bench sweeps the restart distance over every value from well inside the period to past its end, one pulse per distance. It also holds `si` high across whole periods, so that back-to-back restarts and repeated violations occur, and it applies a reset in the middle of a period.

// File: rtl/lss_pkg.sv
package lss_pkg;

    // Width of a pixel number that can hold 0 (idle) through n.
    function automatic int idx_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Control flags derived each cycle from the select register.
    typedef struct packed {
        logic active;   // a period is running
        logic last;     // last pixel presented
        logic launch;   // accepted start token
        logic clash;    // start token seen while active
    } seq_flags_t;

endpackage

// File: rtl/lss_token_chain.sv
module lss_token_chain #(
    parameter int NUM_PIX = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    output logic [NUM_PIX-1:0] stage
);

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= launch;
    end

    for (genvar g = 1; g < NUM_PIX; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[g] <= 1'b0;
            else     stage[g] <= stage[g-1];
        end
    end

endmodule

// File: rtl/lss_pixel_counter.sv
module lss_pixel_counter #(
    parameter int NUM_PIX = 64,
    parameter int IDX_W   = lss_pkg::idx_width(NUM_PIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PIX);

    always_ff @(posedge clk) begin
        if (rst)                 idx <= '0;
        else if (launch)         idx <= IDX_W'(1);
        else if (idx == LAST)    idx <= '0;
        else if (idx != '0)      idx <= idx + IDX_W'(1);
    end

endmodule

// File: rtl/lss_phase_gen.sv
module lss_phase_gen (
    input  logic clk,
    input  logic active,
    output logic sample_hold,
    output logic node_reset
);

    // High phase: sample the selected pixel. Low phase: hold, reset node.
    always_comb begin
        sample_hold = clk & active;
        node_reset  = ~clk;
    end

endmodule

// File: rtl/lss_section_seq.sv
module lss_section_seq #(
    parameter int NUM_PIX = 64
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   si,
    output logic [lss_pkg::idx_width(NUM_PIX)-1:0] pix_idx,
    output logic [NUM_PIX-1:0]                     pix_sel,
    output logic                                   out_en,
    output logic                                   sample_hold,
    output logic                                   node_reset,
    output logic                                   so,
    output logic                                   si_violation
);

    import lss_pkg::*;

    localparam int IDX_W = idx_width(NUM_PIX);

    seq_flags_t flags;
    logic       clash_q;

    always_comb begin
        flags.active = |pix_sel;
        flags.last   = pix_sel[NUM_PIX-1];
        flags.launch = si & ~flags.active;
        flags.clash  = si & flags.active;
    end

    lss_token_chain #(.NUM_PIX(NUM_PIX)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .launch (flags.launch),
        .stage  (pix_sel)
    );

    lss_pixel_counter #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .launch (flags.launch),
        .idx    (pix_idx)
    );

    lss_phase_gen u_phase (
        .clk         (clk),
        .active      (flags.active),
        .sample_hold (sample_hold),
        .node_reset  (node_reset)
    );

    always_ff @(posedge clk) begin
        if (rst) clash_q <= 1'b0;
        else     clash_q <= flags.clash;
    end

    assign out_en       = flags.active;
    assign so           = flags.last;
    assign si_violation = clash_q;

    // R1: an accepted start presents pixel 1 on the next cycle
    a_r1_start: assert property (@(posedge clk) disable iff (rst)
        (si && !out_en) |=> (pix_idx == IDX_W'(1) && pix_sel[0]));

    // R2: counter and token chain agree on the selected pixel
    a_r2_sel_match: assert property (@(posedge clk) disable iff (rst)
        (pix_idx != '0) |-> pix_sel[pix_idx - IDX_W'(1)]);

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pix_sel));

    // R3: chain output only with the last pixel
    a_r3_so_last: assert property (@(posedge clk) disable iff (rst)
        so |-> (pix_idx == IDX_W'(NUM_PIX)));

    // R4: the edge after the last pixel closes the period
    a_r4_close: assert property (@(posedge clk) disable iff (rst)
        (pix_idx == IDX_W'(NUM_PIX)) |=> (!out_en && pix_idx == '0));

    // R5: enable tracks a nonzero pixel number
    a_r5_enable: assert property (@(posedge clk) disable iff (rst)
        out_en == (pix_idx != '0));

    // R8: a start during a period is flagged for one cycle
    a_r8_flag: assert property (@(posedge clk) disable iff (rst)
        (si && out_en) |=> si_violation);

    a_r8_no_flag: assert property (@(posedge clk) disable iff (rst)
        !(si && out_en) |=> !si_violation);

endmodule

// File: tb/lss_section_seq_tb.sv
module lss_section_seq_tb;

    localparam int NPIX = 64;
    localparam int IW   = $clog2(NPIX + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            si  = 1'b0;
    logic [IW-1:0]   pix_idx;
    logic [NPIX-1:0] pix_sel;
    logic            out_en, sample_hold, node_reset, so, si_violation;

    int checks = 0;
    int errors = 0;
    int ref_idx = 0;
    int ref_viol = 0;
    bit done = 1'b0;

    lss_section_seq #(.NUM_PIX(NPIX)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .si           (si),
        .pix_idx      (pix_idx),
        .pix_sel      (pix_sel),
        .out_en       (out_en),
        .sample_hold  (sample_hold),
        .node_reset   (node_reset),
        .so           (so),
        .si_violation (si_violation)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the reference at the edge, check both phases.
    task automatic step();
        logic [NPIX-1:0] exp_sel;
        @(posedge clk);
        if (rst) begin
            ref_idx = 0;
            ref_viol = 0;
        end else begin
            ref_viol = (si && ref_idx != 0) ? 1 : 0;
            if (ref_idx == 0) ref_idx = si ? 1 : 0;
            else              ref_idx = (ref_idx == NPIX) ? 0 : ref_idx + 1;
        end
        #1;
        exp_sel = (ref_idx == 0) ? '0 : (NPIX'(1) << (ref_idx - 1));
        chk("R2 pix_idx", pix_idx, ref_idx);
        chk("R2 pix_sel", pix_sel, exp_sel);
        chk("R5 out_en", out_en, ref_idx != 0);
        chk("R3 so", so, ref_idx == NPIX);
        chk("R8 si_violation", si_violation, ref_viol);
        chk("R6 sample_hold high phase", sample_hold, ref_idx != 0);
        chk("R7 node_reset high phase", node_reset, 0);
        @(negedge clk);
        #1;
        chk("R6 sample_hold low phase", sample_hold, 0);
        chk("R7 node_reset low phase", node_reset, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Pulse si on one edge, then wait gap-1 more edges and pulse again.
    task automatic pulse_pair(input int gap);
        si = 1'b1; step(); si = 1'b0;
        idle(gap - 1);
        si = 1'b1; step(); si = 1'b0;
        idle(NPIX + 4);
    endtask

    initial begin
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R9: reset state
        chk("R9 reset idx", pix_idx, 0);
        chk("R9 reset sel", pix_sel, 0);
        chk("R9 reset out_en/so/flag", {out_en, so, si_violation}, 0);

        // R1, R2, R3, R4: one full period
        si = 1'b1; step(); si = 1'b0;
        chk("R1 first pixel", pix_idx, 1);
        idle(NPIX - 1);
        chk("R3 so with last pixel", so, 1);
        step();
        chk("R4 closed after edge 65", {out_en, pix_idx}, 0);
        idle(5);

        // R8: restart distances around the period boundary
        for (int gap = 50; gap <= 72; gap++) pulse_pair(gap);
        for (int gap = 1; gap <= 4; gap++) pulse_pair(gap);

        // R8: si held high across several periods
        si = 1'b1; idle(3 * (NPIX + 2) + 5); si = 1'b0;
        idle(NPIX + 3);

        // R9: reset in the middle of a period
        si = 1'b1; step(); si = 1'b0;
        idle(20);
        rst = 1'b1; step(); rst = 1'b0;
        chk("R9 mid-period reset", {out_en, pix_idx, so}, 0);
        idle(5);
        si = 1'b1; step(); si = 1'b0;
        chk("R1 start after reset", pix_idx, 1);
        idle(NPIX + 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule